// File: doc/BRIEF.md
# Physical Register Dependency Tracker

This block records, for every physical register of an out-of-order core, which in-flight instructions are waiting for that register's value. Each register owns a singly linked list. The head of the list sits in a per-register table and holds the producer tag together with a pointer to the newest consumer. The consumer nodes come from one shared pool. A free stack hands out pool slots and takes them back. Instructions are named by a fixed-width tag.

An outside controller issues one command at a time. The commands are: set or clear a register's producer, insert a consumer, pop the newest consumer, remove a named consumer, and clear the whole structure. Most commands finish in a single clock. Removal walks the list one node per cycle and holds a busy flag while it runs. Any command presented while busy is high is dropped. The controller also sees a per-register empty flag, a global empty flag, and a pool-exhausted flag. Two counters show how much list walking and unlinking has been done.

Top module: `dtk_dep_tracker`

## Requirements
- R1: After reset every list is empty, `all_empty` is 1, `pool_full` is 0, no register has a valid producer, and both counters read zero.
- R2: An accepted insert (`cmd_op` = 3) places the consumer at the front of its register's list. Successive pops of that register return tags newest first.
- R3: A pop (`cmd_op` = 5) raises `pop_ack` for one cycle after the accepting edge. `pop_hit` is 1 and `pop_tag` carries the newest consumer, which is unlinked. On an empty list `pop_hit` is 0 and nothing changes.
- R4: A remove (`cmd_op` = 4) on a non-empty list unlinks the newest node whose tag matches, keeps the other nodes in order, and pulses `rm_done` k+1 cycles after the accepting edge when the match is at position k (0 = newest).
- R5: A remove on a register with no consumers pulses `rm_done` in the cycle after the accepting edge, with `rm_err` low and no change.
- R6: A remove that reaches the end of the list without a match pulses `rm_err` together with `rm_done`, after visiting every node, and leaves the list unchanged.
- R7: Set producer (`cmd_op` = 1) and clear producer (`cmd_op` = 2) change only the producer valid bit and tag of that register, which read back on `rd_prod_valid`/`rd_prod_tag` for `rd_reg`. Consumer lists stay as they were.
- R8: `reg_empty[r]` is 1 exactly when register r has no consumer. `all_empty` is 1 exactly when every list is empty.
- R9: `pool_full` is 1 when every pool node is in use. An insert issued then is refused and changes no list.
- R10: While `busy` is high, any command presented is ignored.
- R11: `visit_cnt` increases by one for every node a remove examines. `removed_cnt` increases by one for every node a remove unlinks. Pops affect neither counter.
- R12: A clear command (`cmd_op` = 6) empties every list, invalidates every producer, returns all nodes to the pool, and zeroes both counters.
- R13: Nodes released by pop or remove can be allocated again, so an insert succeeds right after a pop frees a slot in a full pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 none, 1 set producer, 2 clear producer, 3 insert, 4 remove, 5 pop, 6 clear |
| cmd_reg | input | $clog2(NREG) | Register selecting the list |
| cmd_tag | input | TAG_W | Instruction tag for producer, insert or remove |
| busy | output | 1 | Remove walk in progress, commands dropped |
| pool_full | output | 1 | No free node left |
| pop_ack | output | 1 | Pop response strobe |
| pop_hit | output | 1 | Pop found a consumer |
| pop_tag | output | TAG_W | Tag returned by the last successful pop |
| rm_done | output | 1 | Remove finished |
| rm_err | output | 1 | Remove found no matching tag |
| rd_reg | input | $clog2(NREG) | Register whose producer is shown |
| rd_prod_valid | output | 1 | Producer valid for `rd_reg` |
| rd_prod_tag | output | TAG_W | Producer tag for `rd_reg` |
| reg_empty | output | NREG | Per-register no-consumer flags |
| all_empty | output | 1 | No consumer on any register |
| visit_cnt | output | CNT_W | Nodes examined by removes |
| removed_cnt | output | CNT_W | Nodes unlinked by removes |

## Verification
The bound checker tests these rules on every cycle:
- a pop on an empty list answers with a miss;
- an accepted insert clears its register's empty flag;
- a refused insert leaves the pool full and every flag unchanged;
- producer commands leave the flags alone;
- the visit counter steps exactly once per busy cycle and holds while the walk is idle;
- an error strobe always comes with a done strobe;
- the global empty flag never coexists with an exhausted pool.

Only the bench scenarios can show the rest:
- the LIFO order of returned tags;
- that removal unlinks the right node and keeps the others in order;
- the exact walk latency for each match position;
- commands dropped while busy;
- node recycling after the pool fills.

// File: rtl/dtk_pkg.sv
package dtk_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_SETP = 3'd1,
    OP_CLRP = 3'd2,
    OP_INS  = 3'd3,
    OP_REM  = 3'd4,
    OP_POP  = 3'd5,
    OP_CLR  = 3'd6
  } dtk_op_e;
endpackage

// File: rtl/dtk_free_stack.sv
module dtk_free_stack #(
  parameter int NNODE = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] top_idx,
  output logic             empty
);
  localparam int CNT_W = $clog2(NNODE + 1);

  logic [IDX_W-1:0] stk [NNODE];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = CNT_W'(NNODE);
    else if (push) cnt_d = cnt_q + CNT_W'(1);
    else if (pop)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(NNODE);
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NNODE; i++) begin : g_slot
    logic [IDX_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q <= IDX_W'(i);
      else if (clear)                          slot_q <= IDX_W'(i);
      else if (push && (cnt_q == CNT_W'(i)))   slot_q <= push_idx;
    end
    assign stk[i] = slot_q;
  end

  assign top_idx = stk[IDX_W'(cnt_q - CNT_W'(1))];
  assign empty   = (cnt_q == '0);
endmodule

// File: rtl/dtk_node_mem.sv
module dtk_node_mem #(
  parameter int NNODE = 16,
  parameter int IDX_W = 4,
  parameter int PTR_W = 5,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             we_tag,
  input  logic             we_next,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PTR_W-1:0] wr_next,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PTR_W-1:0] rd_next
);
  logic [TAG_W-1:0] tag_mem  [NNODE];
  logic [PTR_W-1:0] next_mem [NNODE];

  always_ff @(posedge clk) begin
    if (we_tag)  tag_mem[wr_idx]  <= wr_tag;
    if (we_next) next_mem[wr_idx] <= wr_next;
  end

  assign rd_tag  = tag_mem[rd_idx];
  assign rd_next = next_mem[rd_idx];
endmodule

// File: rtl/dtk_reg_table.sv
module dtk_reg_table #(
  parameter int NREG   = 8,
  parameter int RIDX_W = 3,
  parameter int PTR_W  = 5,
  parameter int TAG_W  = 6,
  parameter int NIL    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              we_head,
  input  logic [RIDX_W-1:0] head_reg,
  input  logic [PTR_W-1:0]  head_val,
  output logic [PTR_W-1:0]  head_out,
  input  logic              set_prod,
  input  logic              clr_prod,
  input  logic [RIDX_W-1:0] prod_reg,
  input  logic [TAG_W-1:0]  prod_tag,
  input  logic [RIDX_W-1:0] rd_reg,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [NREG-1:0]   empty_vec
);
  logic [PTR_W-1:0] head_arr [NREG];
  logic             pv_arr   [NREG];
  logic [TAG_W-1:0] pt_arr   [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [PTR_W-1:0] head_q;
    logic             pv_q;
    logic [TAG_W-1:0] pt_q;
    logic             hit_h, hit_p;

    assign hit_h = we_head && (head_reg == RIDX_W'(r));
    assign hit_p = (prod_reg == RIDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q <= PTR_W'(NIL);
        pv_q   <= 1'b0;
      end else begin
        if (clear)      head_q <= PTR_W'(NIL);
        else if (hit_h) head_q <= head_val;
        if (clear)                 pv_q <= 1'b0;
        else if (set_prod && hit_p) pv_q <= 1'b1;
        else if (clr_prod && hit_p) pv_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (set_prod && hit_p) pt_q <= prod_tag;
    end

    assign head_arr[r]  = head_q;
    assign pv_arr[r]    = pv_q;
    assign pt_arr[r]    = pt_q;
    assign empty_vec[r] = (head_q == PTR_W'(NIL));
  end

  assign head_out = head_arr[head_reg];
  assign rd_valid = pv_arr[rd_reg];
  assign rd_tag   = pt_arr[rd_reg];
endmodule

// File: rtl/dtk_dep_tracker.sv
module dtk_dep_tracker #(
  parameter int NREG  = 8,
  parameter int NNODE = 16,
  parameter int TAG_W = 6,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(NREG)-1:0]   cmd_reg,
  input  logic [TAG_W-1:0]          cmd_tag,
  output logic                      busy,
  output logic                      pool_full,
  output logic                      pop_ack,
  output logic                      pop_hit,
  output logic [TAG_W-1:0]          pop_tag,
  output logic                      rm_done,
  output logic                      rm_err,
  input  logic [$clog2(NREG)-1:0]   rd_reg,
  output logic                      rd_prod_valid,
  output logic [TAG_W-1:0]          rd_prod_tag,
  output logic [NREG-1:0]           reg_empty,
  output logic                      all_empty,
  output logic [CNT_W-1:0]          visit_cnt,
  output logic [CNT_W-1:0]          removed_cnt
);
  import dtk_pkg::*;

  localparam int RIDX_W = $clog2(NREG);
  localparam int IDX_W  = $clog2(NNODE);
  localparam int PTR_W  = IDX_W + 1;
  localparam logic [PTR_W-1:0] NIL = PTR_W'(NNODE);

  dtk_op_e op;
  assign op = dtk_op_e'(cmd_op);

  // walker state
  logic              busy_q, busy_d;
  logic [RIDX_W-1:0] rm_reg_q, rm_reg_d;
  logic [TAG_W-1:0]  rm_tag_q, rm_tag_d;
  logic [PTR_W-1:0]  rm_prev_q, rm_prev_d;
  logic [PTR_W-1:0]  rm_cur_q, rm_cur_d;
  logic [CNT_W-1:0]  vis_q, vis_d, rem_q, rem_d;
  logic              pop_ack_d, pop_hit_d, rm_done_d, rm_err_d, tag_en;
  logic              pop_ack_q, pop_hit_q, rm_done_q, rm_err_q;
  logic [TAG_W-1:0]  pop_tag_q;

  // datapath controls
  logic              clear_all, set_prod, clr_prod, we_head;
  logic [PTR_W-1:0]  head_val, rd_head;
  logic [RIDX_W-1:0] tbl_reg;
  logic              nm_we_tag, nm_we_next;
  logic [IDX_W-1:0]  nm_wr_idx, nm_rd_idx;
  logic [PTR_W-1:0]  nm_wr_next, rd_next;
  logic [TAG_W-1:0]  rd_tag;
  logic              fs_push, fs_pop, fs_empty;
  logic [IDX_W-1:0]  fs_push_idx, fs_top;

  assign tbl_reg   = busy_q ? rm_reg_q : cmd_reg;
  assign nm_rd_idx = busy_q ? IDX_W'(rm_cur_q) : IDX_W'(rd_head);

  dtk_reg_table #(
    .NREG(NREG), .RIDX_W(RIDX_W), .PTR_W(PTR_W), .TAG_W(TAG_W), .NIL(NNODE)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n), .clear(clear_all),
    .we_head(we_head), .head_reg(tbl_reg), .head_val(head_val), .head_out(rd_head),
    .set_prod(set_prod), .clr_prod(clr_prod), .prod_reg(cmd_reg), .prod_tag(cmd_tag),
    .rd_reg(rd_reg), .rd_valid(rd_prod_valid), .rd_tag(rd_prod_tag),
    .empty_vec(reg_empty)
  );

  dtk_node_mem #(
    .NNODE(NNODE), .IDX_W(IDX_W), .PTR_W(PTR_W), .TAG_W(TAG_W)
  ) u_nodes (
    .clk(clk), .we_tag(nm_we_tag), .we_next(nm_we_next), .wr_idx(nm_wr_idx),
    .wr_tag(cmd_tag), .wr_next(nm_wr_next), .rd_idx(nm_rd_idx),
    .rd_tag(rd_tag), .rd_next(rd_next)
  );

  dtk_free_stack #(
    .NNODE(NNODE), .IDX_W(IDX_W)
  ) u_free (
    .clk(clk), .rst_n(rst_n), .clear(clear_all), .push(fs_push),
    .push_idx(fs_push_idx), .pop(fs_pop), .top_idx(fs_top), .empty(fs_empty)
  );

  always_comb begin
    busy_d    = busy_q;
    rm_reg_d  = rm_reg_q;
    rm_tag_d  = rm_tag_q;
    rm_prev_d = rm_prev_q;
    rm_cur_d  = rm_cur_q;
    vis_d     = vis_q;
    rem_d     = rem_q;
    pop_ack_d = 1'b0;
    pop_hit_d = 1'b0;
    tag_en    = 1'b0;
    rm_done_d = 1'b0;
    rm_err_d  = 1'b0;
    clear_all = 1'b0;
    set_prod  = 1'b0;
    clr_prod  = 1'b0;
    we_head   = 1'b0;
    head_val  = rd_next;
    nm_we_tag  = 1'b0;
    nm_we_next = 1'b0;
    nm_wr_idx  = fs_top;
    nm_wr_next = rd_head;
    fs_push     = 1'b0;
    fs_pop      = 1'b0;
    fs_push_idx = IDX_W'(rd_head);
    if (busy_q) begin
      vis_d = vis_q + CNT_W'(1);
      if (rd_tag == rm_tag_q) begin
        if (rm_prev_q == NIL) begin
          we_head = 1'b1;
        end else begin
          nm_we_next = 1'b1;
          nm_wr_idx  = IDX_W'(rm_prev_q);
          nm_wr_next = rd_next;
        end
        fs_push     = 1'b1;
        fs_push_idx = IDX_W'(rm_cur_q);
        rem_d       = rem_q + CNT_W'(1);
        busy_d      = 1'b0;
        rm_done_d   = 1'b1;
      end else if (rd_next == NIL) begin
        busy_d    = 1'b0;
        rm_done_d = 1'b1;
        rm_err_d  = 1'b1;
      end else begin
        rm_prev_d = rm_cur_q;
        rm_cur_d  = rd_next;
      end
    end else if (cmd_valid) begin
      case (op)
        OP_SETP: set_prod = 1'b1;
        OP_CLRP: clr_prod = 1'b1;
        OP_INS: begin
          if (!fs_empty) begin
            fs_pop     = 1'b1;
            nm_we_tag  = 1'b1;
            nm_we_next = 1'b1;
            we_head    = 1'b1;
            head_val   = {1'b0, fs_top};
          end
        end
        OP_POP: begin
          pop_ack_d = 1'b1;
          if (rd_head != NIL) begin
            pop_hit_d = 1'b1;
            tag_en    = 1'b1;
            we_head   = 1'b1;
            fs_push   = 1'b1;
          end
        end
        OP_REM: begin
          if (rd_head == NIL) begin
            rm_done_d = 1'b1;
          end else begin
            busy_d    = 1'b1;
            rm_reg_d  = cmd_reg;
            rm_tag_d  = cmd_tag;
            rm_prev_d = NIL;
            rm_cur_d  = rd_head;
          end
        end
        OP_CLR: begin
          clear_all = 1'b1;
          vis_d     = '0;
          rem_d     = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      vis_q     <= '0;
      rem_q     <= '0;
      pop_ack_q <= 1'b0;
      pop_hit_q <= 1'b0;
      rm_done_q <= 1'b0;
      rm_err_q  <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      vis_q     <= vis_d;
      rem_q     <= rem_d;
      pop_ack_q <= pop_ack_d;
      pop_hit_q <= pop_hit_d;
      rm_done_q <= rm_done_d;
      rm_err_q  <= rm_err_d;
    end
  end

  always_ff @(posedge clk) begin
    rm_reg_q  <= rm_reg_d;
    rm_tag_q  <= rm_tag_d;
    rm_prev_q <= rm_prev_d;
    rm_cur_q  <= rm_cur_d;
    if (tag_en) pop_tag_q <= rd_tag;
  end

  assign busy        = busy_q;
  assign pool_full   = fs_empty;
  assign pop_ack     = pop_ack_q;
  assign pop_hit     = pop_hit_q;
  assign pop_tag     = pop_tag_q;
  assign rm_done     = rm_done_q;
  assign rm_err      = rm_err_q;
  assign all_empty   = &reg_empty;
  assign visit_cnt   = vis_q;
  assign removed_cnt = rem_q;
endmodule

// File: rtl/dtk_dep_tracker_chk.sv
module dtk_dep_tracker_chk #(
  parameter int NREG  = 8,
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [2:0]              cmd_op,
  input logic [$clog2(NREG)-1:0] cmd_reg,
  input logic                    busy,
  input logic                    pool_full,
  input logic                    pop_ack,
  input logic                    pop_hit,
  input logic                    rm_done,
  input logic                    rm_err,
  input logic [NREG-1:0]         reg_empty,
  input logic                    all_empty,
  input logic [CNT_W-1:0]        visit_cnt,
  input logic [CNT_W-1:0]        removed_cnt
);
  logic acc;
  assign acc = cmd_valid && !busy;

  AST_POP_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd5 && reg_empty[cmd_reg]) |=> (pop_ack && !pop_hit)); // R3

  AST_INSERT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd3 && !pool_full) |=> !reg_empty[$past(cmd_reg)]); // R2

  AST_FULL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd3 && pool_full) |=> (pool_full && $stable(reg_empty))); // R9

  AST_PROD_NO_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == 3'd1 || cmd_op == 3'd2)) |=> ($stable(reg_empty) && $stable(pool_full))); // R7

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rm_err |-> rm_done); // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rm_done |-> !busy); // R4

  AST_VISIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (visit_cnt == $past(visit_cnt) + CNT_W'(1))); // R11

  AST_VISIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cmd_op == 3'd6)) |=> ($stable(visit_cnt) && $stable(removed_cnt))); // R11

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd6) |=> (all_empty && !pool_full && visit_cnt == '0 && removed_cnt == '0)); // R12

  AST_EMPTY_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    all_empty |-> !pool_full); // R8
endmodule

bind dtk_dep_tracker dtk_dep_tracker_chk #(.NREG(NREG), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
  .busy(busy), .pool_full(pool_full), .pop_ack(pop_ack), .pop_hit(pop_hit),
  .rm_done(rm_done), .rm_err(rm_err), .reg_empty(reg_empty), .all_empty(all_empty),
  .visit_cnt(visit_cnt), .removed_cnt(removed_cnt)
);

// File: tb/dtk_dep_tracker_bench.sv
`timescale 1ns/1ps
module dtk_dep_tracker_bench;
  localparam int NREG  = 8;
  localparam int NNODE = 16;
  localparam int TAG_W = 6;
  localparam int CNT_W = 16;
  localparam int RW    = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [2:0] cmd_op;
  logic [RW-1:0] cmd_reg, rd_reg;
  logic [TAG_W-1:0] cmd_tag, pop_tag, rd_prod_tag;
  logic busy, pool_full, pop_ack, pop_hit, rm_done, rm_err, rd_prod_valid, all_empty;
  logic [NREG-1:0] reg_empty;
  logic [CNT_W-1:0] visit_cnt, removed_cnt;

  always #2 clk = ~clk;

  dtk_dep_tracker #(.NREG(NREG), .NNODE(NNODE), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_dtk_dep_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
    .cmd_tag(cmd_tag), .busy(busy), .pool_full(pool_full), .pop_ack(pop_ack),
    .pop_hit(pop_hit), .pop_tag(pop_tag), .rm_done(rm_done), .rm_err(rm_err),
    .rd_reg(rd_reg), .rd_prod_valid(rd_prod_valid), .rd_prod_tag(rd_prod_tag),
    .reg_empty(reg_empty), .all_empty(all_empty), .visit_cnt(visit_cnt),
    .removed_cnt(removed_cnt)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;
  int mq [NREG][$];
  bit mpv [NREG];
  int mpt [NREG];
  int mvis = 0, mrem = 0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int used_nodes();
    int s = 0;
    for (int r = 0; r < NREG; r++) s += mq[r].size();
    return s;
  endfunction

  function automatic int find_pos(input int r, input int t);
    for (int i = 0; i < mq[r].size(); i++) if (mq[r][i] == t) return i;
    return -1;
  endfunction

  task automatic model_clear();
    for (int r = 0; r < NREG; r++) begin
      mq[r].delete();
      mpv[r] = 0;
      mpt[r] = 0;
    end
    mvis = 0;
    mrem = 0;
  endtask

  task automatic compare_state();
    bit ae = 1;
    for (int r = 0; r < NREG; r++) begin
      chk("R8 reg_empty", int'(reg_empty[r]), int'(mq[r].size() == 0));
      if (mq[r].size() != 0) ae = 0;
      rd_reg = RW'(r);
      #0.1;
      chk("R7 prod_valid", int'(rd_prod_valid), int'(mpv[r]));
      if (mpv[r]) chk("R7 prod_tag", int'(rd_prod_tag), mpt[r]);
    end
    chk("R8 all_empty", int'(all_empty), int'(ae));
    chk("R9 pool_full", int'(pool_full), int'(used_nodes() == NNODE));
    chk("R11 visit_cnt", int'(visit_cnt), mvis);
    chk("R11 removed_cnt", int'(removed_cnt), mrem);
  endtask

  task automatic send(input logic [2:0] op, input int r, input int t);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_reg   = RW'(r);
    cmd_tag   = TAG_W'(t);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
    @(negedge clk);
  endtask

  task automatic do_ins(input int r, input int t);
    bit ok = (used_nodes() < NNODE);
    send(3'd3, r, t);
    if (ok) mq[r].push_front(t);
  endtask

  task automatic do_pop(input int r);
    send(3'd5, r, 0);
    chk("R3 pop_ack", int'(pop_ack), 1);
    chk("R3 pop_hit", int'(pop_hit), int'(mq[r].size() != 0));
    if (mq[r].size() != 0) begin
      chk("R2 pop_tag newest", int'(pop_tag), mq[r][0]);
      void'(mq[r].pop_front());
    end
  endtask

  task automatic do_rem(input int r, input int t, input bit intrude, input int ireg);
    int k, n, sz, expn;
    bit experr;
    sz = mq[r].size();
    k  = find_pos(r, t);
    if (sz == 0)     begin expn = 0;     experr = 0; end
    else if (k < 0)  begin expn = sz;    experr = 1; end
    else             begin expn = k + 1; experr = 0; end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_reg = RW'(r); cmd_tag = TAG_W'(t);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    n = 0;
    @(negedge clk);
    while (!rm_done && n < NNODE + 4) begin
      if (intrude && n == 0) begin
        chk("R10 busy during walk", int'(busy), 1);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_reg = RW'(ireg); cmd_tag = TAG_W'(7);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
      end else begin
        @(posedge clk);
      end
      @(negedge clk);
      n++;
    end
    chk("R4 walk latency", n, expn);
    chk(sz == 0 ? "R5 rm_err" : "R6 rm_err", int'(rm_err), int'(experr));
    mvis += expn;
    if (sz != 0 && k >= 0) begin
      mq[r].delete(k);
      mrem++;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int v, r, t;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_reg = '0; cmd_tag = '0; rd_reg = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 all_empty", int'(all_empty), 1);
    chk("R1 pool_full", int'(pool_full), 0);
    chk("R1 busy", int'(busy), 0);
    compare_state();

    // R2 LIFO order, R3 empty pop
    do_ins(2, 11); do_ins(2, 22); do_ins(2, 33);
    compare_state();
    do_pop(2); do_pop(2); do_pop(2); do_pop(2);
    compare_state();

    // R4 middle and oldest removal, R10 dropped command, R6 miss, R5 empty
    for (int i = 0; i < 5; i++) do_ins(3, 40 + i);
    do_rem(3, 42, 0, 0);
    compare_state();
    do_rem(3, 40, 1, 5);
    chk("R10 intruding insert dropped", int'(reg_empty[5]), 1);
    compare_state();
    do_rem(3, 60, 0, 0);
    do_rem(6, 1, 0, 0);
    compare_state();
    do_pop(3); do_pop(3); do_pop(3);

    // R7 producer fields do not disturb lists
    do_ins(1, 9);
    send(3'd1, 1, 17); mpv[1] = 1; mpt[1] = 17;
    send(3'd1, 4, 50); mpv[4] = 1; mpt[4] = 50;
    compare_state();
    send(3'd2, 1, 0); mpv[1] = 0;
    compare_state();

    // R9 pool exhaustion, R13 recycling
    for (int i = 0; i < NNODE; i++) do_ins(i % NREG, i);
    chk("R9 full flag", int'(pool_full), 1);
    do_ins(0, 63);
    compare_state();
    do_pop(0);
    do_ins(7, 61);
    chk("R13 recycled insert", int'(reg_empty[7]), 0);
    do_rem(7, 61, 0, 0);
    do_ins(4, 62);
    compare_state();

    // R12 clear command
    send(3'd6, 0, 0);
    model_clear();
    compare_state();

    // random mix
    for (int it = 0; it < 2500; it++) begin
      v = $urandom_range(0, 99);
      r = $urandom_range(0, NREG - 1);
      t = $urandom_range(0, 63);
      if (v < 38) do_ins(r, t);
      else if (v < 56) do_pop(r);
      else if (v < 78) begin
        if (mq[r].size() != 0 && $urandom_range(0, 9) < 7)
          t = mq[r][$urandom_range(0, mq[r].size() - 1)];
        do_rem(r, t, 0, 0);
      end
      else if (v < 88) begin send(3'd1, r, t); mpv[r] = 1; mpt[r] = t; end
      else if (v < 95) begin send(3'd2, r, 0); mpv[r] = 0; end
      else if (v < 96) begin send(3'd6, 0, 0); model_clear(); end
      else send(3'd0, r, t);
      compare_state();
    end

    finished = 1;
    finish_run();
  end
endmodule